// File: doc/BRIEF.md
# I/O Address Formation and Pseudo-Transaction Unit

This unit accepts one decoded I/O request at a time and turns it into a 32-bit I/O address and a bus cycle. The request carries an operation class, the immediate operand bytes, the accumulator byte, the 32-bit BC register value, a read/write flag and a write data byte. External classes build the address from the operand bytes or from BC. They then run one bus cycle with a read or write strobe.

The on-chip class never reaches the external bus. It runs a two-cycle pseudo-transaction. The register number appears on the low address byte, the upper address bits are zero and both strobes stay low. Meanwhile a one-hot select reaches a small register file. That file holds three writable 8-bit registers and a read-only version register. A done pulse marks the last cycle of every transaction, and busy is high for its whole length.

Top module: `io_addr_unit`

## Requirements
- R1: After a synchronous active-low reset, busy, done, io_rd, io_wr, oc_sel, oc_we and rdata are 0, io_addr is 0, and all writable on-chip registers read 00H. Whenever busy is 0, io_addr is 0 and both strobes are 0.
- R2: The immediate-byte class (req_op = 0) drives io_addr = {16'h0000, acc, imm_n}.
- R3: The register-indirect class (req_op = 1) and the block class (req_op = 5) drive io_addr = bc.
- R4: The direct classes drive the following, with zeros above the supplied bytes:
  - req_op = 2: {16'h0, m, n}
  - req_op = 3: {8'h0, l, m, n}
  - req_op = 4: {k, l, m, n}
- R5: An accepted external request runs exactly one bus cycle. This is the cycle after the accepting clock edge. In it busy = 1 and done = 1, io_rd = 1 for a read (req_write = 0), io_wr = 1 for a write, and never both. The unit is idle in the following cycle.
- R6: An accepted on-chip request (req_op = 6) lasts exactly two cycles with busy = 1. In both cycles io_addr = {24'h0, imm_n} and io_rd = io_wr = 0. done is 0 in the first cycle and 1 in the second.
- R7: The writable registers sit at 17H (interrupt enable), 18H (vector base) and 19H (trap/break). A write updates the register at the clock edge that ends the second pseudo-cycle. A later on-chip read presents the stored value on rdata during its second cycle.
- R8: A read of 0FFH returns 00H and a write to it has no effect. Any other unmapped address reads 00H, and writing it changes no register. rdata is 0 outside the second cycle of an on-chip read.
- R9: A request presented while busy is 1 is ignored, and so is a request with req_op = 7. In both cases no transaction starts and the outputs do not change.
- R10: During both pseudo-cycles oc_sel is one-hot on the addressed register: bit 0 for 17H, bit 1 for 18H, bit 2 for 19H, bit 3 for 0FFH. It is 0 for unmapped addresses and outside on-chip transactions. oc_we is 1 only in the second cycle of a write to 17H, 18H or 19H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation class (0 imm-byte, 1 reg-indirect, 2/3/4 direct 16/24/32, 5 block, 6 on-chip, 7 reserved) |
| req_write | input | 1 | 1 = output/write, 0 = input/read |
| imm_n | input | 8 | Operand byte n (lowest) |
| imm_m | input | 8 | Operand byte m |
| imm_l | input | 8 | Operand byte l |
| imm_k | input | 8 | Operand byte k (highest) |
| acc | input | 8 | Accumulator byte for the immediate-byte class |
| bc | input | 32 | BC register value |
| req_wdata | input | 8 | Write data for on-chip registers |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last cycle of a transaction |
| io_addr | output | 32 | I/O address bus |
| io_rd | output | 1 | External read strobe |
| io_wr | output | 1 | External write strobe |
| oc_sel | output | 4 | One-hot on-chip register select |
| oc_we | output | 1 | On-chip register write commit |
| rdata | output | 8 | On-chip read data |

## Verification
The bench sweeps each address class over many operand patterns, so a byte placed in the wrong lane or a nonzero upper byte is caught. It checks all 256 on-chip addresses before and after writes. A design that strobed the external bus during a pseudo-transaction, or stretched it to one or three cycles, would fail the per-cycle checks. So would a design that decoded the unmapped space as an alias, or let a write to the version register or an unmapped address land in a real register. Requests raised while the unit is busy, and requests with the reserved class, are checked for starting nothing. A design that queued them or started them would show a spurious busy or address.

// File: rtl/io_addr_pkg.sv
// Package: shared types for the I/O address unit.
// Assumes: operation class codes are fixed by the instruction decoder.
package io_addr_pkg;
    localparam int ADDR_W = 32;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_IMM8   = 3'd0,
        OP_REGC   = 3'd1,
        OP_DIR16  = 3'd2,
        OP_DIR24  = 3'd3,
        OP_DIR32  = 3'd4,
        OP_BLOCK  = 3'd5,
        OP_ONCHIP = 3'd6,
        OP_RSVD   = 3'd7
    } io_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXT  = 2'd1,
        ST_PS1  = 2'd2,
        ST_PS2  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/io_addr_compose.sv
// Module: io_addr_compose
// Builds the 32-bit I/O address from the operation class and operands.
// Purely combinational; assumes a 32-bit address made of four bytes.
module io_addr_compose
    import io_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  io_op_e        op,
    input  logic [BW-1:0] b_n,
    input  logic [BW-1:0] b_m,
    input  logic [BW-1:0] b_l,
    input  logic [BW-1:0] b_k,
    input  logic [BW-1:0] b_acc,
    input  logic [AW-1:0] b_bc,
    output logic [AW-1:0] addr
);
    localparam int LANES = AW / BW;

    logic [BW-1:0] lane [LANES];

    // Selects each byte lane from the operand set per class.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane[i] = '0;
        end
        unique case (op)
            OP_IMM8: begin
                lane[0] = b_n;
                lane[1] = b_acc;
            end
            OP_REGC, OP_BLOCK: begin
                for (int i = 0; i < LANES; i++) begin
                    lane[i] = b_bc[i*BW +: BW];
                end
            end
            OP_DIR16: begin
                lane[0] = b_n;
                lane[1] = b_m;
            end
            OP_DIR24: begin
                lane[0] = b_n;
                lane[1] = b_m;
                lane[2] = b_l;
            end
            OP_DIR32: begin
                lane[0] = b_n;
                lane[1] = b_m;
                lane[2] = b_l;
                lane[3] = b_k;
            end
            OP_ONCHIP: begin
                lane[0] = b_n;
            end
            default: begin
                for (int i = 0; i < LANES; i++) begin
                    lane[i] = '0;
                end
            end
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_pack
            assign addr[g*BW +: BW] = lane[g];
        end
    endgenerate
endmodule

// File: rtl/io_seq.sv
// Module: io_seq
// Transaction sequencer: one cycle for external I/O, two for on-chip.
// Assumes requests are only sampled while idle; reserved class is refused.
module io_seq
    import io_addr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  io_op_e     req_op,
    output seq_state_e state,
    output logic       accept
);
    seq_state_e state_nx;

    // Accepts a request only when idle and of a legal class.
    assign accept = (state == ST_IDLE) && req_valid && (req_op != OP_RSVD);

    // Next-state decode.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = (req_op == OP_ONCHIP) ? ST_PS1 : ST_EXT;
            ST_EXT:  state_nx = ST_IDLE;
            ST_PS1:  state_nx = ST_PS2;
            ST_PS2:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/io_onchip_regs.sv
// Module: io_onchip_regs
// On-chip register file: writable registers plus a read-only version byte.
// Assumes the last map entry is the read-only version register.
module io_onchip_regs #(
    parameter int                     AB      = 8,
    parameter int                     DW      = 8,
    parameter int                     NUM_OC  = 4,
    parameter logic [NUM_OC*AB-1:0]   OC_MAP  = {8'hFF, 8'h19, 8'h18, 8'h17},
    parameter logic [DW-1:0]          VER_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [AB-1:0]     reg_addr,
    input  logic              commit,
    input  logic [DW-1:0]     wdata,
    output logic [NUM_OC-1:0] sel,
    output logic              we,
    output logic [DW-1:0]     rd_data
);
    localparam int NUM_WR = NUM_OC - 1;

    logic [NUM_OC-1:0] hit;
    logic [DW-1:0]     store [NUM_WR];

    genvar g;
    generate
        for (g = 0; g < NUM_OC; g++) begin : g_dec
            assign hit[g] = (reg_addr == OC_MAP[g*AB +: AB]);
        end
        for (g = 0; g < NUM_WR; g++) begin : g_store
            // Holds one writable register; updates on commit when selected.
            always_ff @(posedge clk) begin
                if (!rst_n)                 store[g] <= '0;
                else if (commit && hit[g])  store[g] <= wdata;
            end
        end
    endgenerate

    assign sel = active ? hit : '0;
    assign we  = commit && (|hit[NUM_WR-1:0]);

    // Read mux: stored value, version constant, or zero when unmapped.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WR; i++) begin
            if (hit[i]) rd_data = store[i];
        end
        if (hit[NUM_OC-1]) rd_data = VER_VAL;
    end
endmodule

// File: rtl/io_addr_unit.sv
// Module: io_addr_unit (top)
// Forms I/O addresses and runs external or on-chip pseudo-transactions.
// Assumes the caller holds request fields valid in the cycle req_valid is high.
module io_addr_unit
    import io_addr_pkg::*;
#(
    parameter int             AW      = ADDR_W,
    parameter int             DW      = BYTE_W,
    parameter int             NUM_OC  = 4,
    parameter logic [NUM_OC*8-1:0] OC_MAP = {8'hFF, 8'h19, 8'h18, 8'h17},
    parameter logic [DW-1:0]  VER_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic              req_write,
    input  logic [7:0]        imm_n,
    input  logic [7:0]        imm_m,
    input  logic [7:0]        imm_l,
    input  logic [7:0]        imm_k,
    input  logic [7:0]        acc,
    input  logic [AW-1:0]     bc,
    input  logic [DW-1:0]     req_wdata,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     io_addr,
    output logic              io_rd,
    output logic              io_wr,
    output logic [NUM_OC-1:0] oc_sel,
    output logic              oc_we,
    output logic [DW-1:0]     rdata
);
    io_op_e        op;
    seq_state_e    state;
    logic          accept;
    logic [AW-1:0] comp_addr;
    logic [AW-1:0] addr_q;
    logic          write_q;
    logic [DW-1:0] wdata_q;
    logic          in_ps;
    logic [DW-1:0] reg_rd;

    assign op = io_op_e'(req_op);

    io_addr_compose #(.AW(AW), .BW(8)) i_compose (
        .op    (op),
        .b_n   (imm_n),
        .b_m   (imm_m),
        .b_l   (imm_l),
        .b_k   (imm_k),
        .b_acc (acc),
        .b_bc  (bc),
        .addr  (comp_addr)
    );

    io_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (op),
        .state     (state),
        .accept    (accept)
    );

    // Captures address, direction and write data at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= comp_addr;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    assign in_ps = (state == ST_PS1) || (state == ST_PS2);

    io_onchip_regs #(
        .AB      (8),
        .DW      (DW),
        .NUM_OC  (NUM_OC),
        .OC_MAP  (OC_MAP),
        .VER_VAL (VER_VAL)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (in_ps),
        .reg_addr (addr_q[7:0]),
        .commit   ((state == ST_PS2) && write_q),
        .wdata    (wdata_q),
        .sel      (oc_sel),
        .we       (oc_we),
        .rd_data  (reg_rd)
    );

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_EXT) || (state == ST_PS2);
    assign io_addr = busy ? addr_q : '0;
    assign io_rd   = (state == ST_EXT) && !write_q;
    assign io_wr   = (state == ST_EXT) && write_q;
    assign rdata   = ((state == ST_PS2) && !write_q) ? reg_rd : '0;
endmodule

// File: rtl/io_addr_unit_chk.sv
// Module: io_addr_unit_chk
// Port-level protocol checker for io_addr_unit, attached by bind.
module io_addr_unit_chk #(
    parameter int AW     = 32,
    parameter int DW     = 8,
    parameter int NUM_OC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [AW-1:0]     io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [NUM_OC-1:0] oc_sel,
    input logic              oc_we,
    input logic [DW-1:0]     rdata
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (io_addr == '0) && !io_rd && !io_wr && !done && (oc_sel == '0));

    assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({io_rd, io_wr}));

    assert_ext_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) |-> done ##1 !io_rd && !io_wr && !busy);

    assert_pseudo_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_sel != '0) |-> (io_addr[AW-1:8] == '0) && !io_rd && !io_wr);

    assert_pseudo_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy && done && $stable(io_addr));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oc_sel));

    assert_we_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oc_we |-> done && (oc_sel != '0));

    assert_rdata_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (rdata == '0));
endmodule

bind io_addr_unit io_addr_unit_chk #(.AW(AW), .DW(DW), .NUM_OC(NUM_OC)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .io_addr (io_addr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .oc_sel  (oc_sel),
    .oc_we   (oc_we),
    .rdata   (rdata)
);

// File: tb/test_io_addr_unit.sv
module test_io_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_write = 1'b0;
    logic [7:0]  imm_n = '0, imm_m = '0, imm_l = '0, imm_k = '0, acc = '0;
    logic [31:0] bc = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, io_rd, io_wr, oc_we;
    logic [31:0] io_addr;
    logic [3:0]  oc_sel;
    logic [7:0]  rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] mdl [3];

    always #4 clk = ~clk;

    io_addr_unit i_io_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_write(req_write), .imm_n(imm_n), .imm_m(imm_m), .imm_l(imm_l),
        .imm_k(imm_k), .acc(acc), .bc(bc), .req_wdata(req_wdata),
        .busy(busy), .done(done), .io_addr(io_addr), .io_rd(io_rd),
        .io_wr(io_wr), .oc_sel(oc_sel), .oc_we(oc_we), .rdata(rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [2:0] op);
        case (op)
            3'd0:      return {16'h0, acc, imm_n};
            3'd1, 3'd5: return bc;
            3'd2:      return {16'h0, imm_m, imm_n};
            3'd3:      return {8'h0, imm_l, imm_m, imm_n};
            3'd4:      return {imm_k, imm_l, imm_m, imm_n};
            default:   return {24'h0, imm_n};
        endcase
    endfunction

    function automatic logic [3:0] exp_sel(input logic [7:0] a);
        case (a)
            8'h17: return 4'b0001;
            8'h18: return 4'b0010;
            8'h19: return 4'b0100;
            8'hFF: return 4'b1000;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h17: return mdl[0];
            8'h18: return mdl[1];
            8'h19: return mdl[2];
            default: return 8'h00;
        endcase
    endfunction

    // Presents a request for one cycle; returns at the negedge of the first transaction cycle.
    task automatic issue(input logic [2:0] op, input logic w);
        @(negedge clk);
        req_op = op; req_write = w; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ext_txn(input string req, input logic [2:0] op, input logic w);
        logic [31:0] ea;
        ea = exp_addr(op);
        issue(op, w);
        check(req, "addr", io_addr, ea);
        check("R5", "busy", busy, 1);
        check("R5", "done", done, 1);
        check("R5", "strobes", {io_rd, io_wr}, w ? 2'b01 : 2'b10);
        @(negedge clk);
        check("R5", "idle after", {busy, done, io_rd, io_wr}, 0);
    endtask

    task automatic oc_txn(input logic [7:0] a, input logic w, input logic [7:0] wd);
        logic [7:0] er;
        er = exp_read(a);
        imm_n = a; req_wdata = wd;
        issue(3'd6, w);
        check("R6", "p1 addr", io_addr, {24'h0, a});
        check("R6", "p1 flags", {busy, done, io_rd, io_wr}, 4'b1000);
        check("R10", "p1 sel", oc_sel, exp_sel(a));
        @(negedge clk);
        check("R6", "p2 flags", {busy, done, io_rd, io_wr}, 4'b1100);
        check("R10", "p2 sel", oc_sel, exp_sel(a));
        check("R10", "p2 we", oc_we, w && (exp_sel(a) & 4'b0111) != 0);
        check(w ? "R8" : "R7", "rdata", rdata, w ? 8'h00 : er);
        if (w) begin
            if (a == 8'h17) mdl[0] = wd;
            if (a == 8'h18) mdl[1] = wd;
            if (a == 8'h19) mdl[2] = wd;
        end
        @(negedge clk);
        check("R6", "idle after", {busy, done}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R1", "reset outputs", {busy, done, io_rd, io_wr, oc_sel, oc_we, rdata}, 0);
        check("R1", "reset addr", io_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle addr", io_addr, 0);

        // R1/R8: every on-chip address reads zero after reset.
        for (int a = 0; a < 256; a++) oc_txn(8'(a), 1'b0, 8'h00);

        // R2/R3/R4/R5: address composition sweep.
        for (int i = 0; i < 48; i++) begin
            for (int op = 0; op < 6; op++) begin
                imm_n = 8'(i * 37 + 5);  imm_m = 8'(i * 59 + 11);
                imm_l = 8'(i * 83 + 23); imm_k = 8'(i * 101 + 7);
                acc   = 8'(i * 13 + 191);
                bc    = 32'h9E37_79B9 * 32'(i + 1) ^ 32'(op);
                ext_txn(op == 0 ? "R2" : (op == 1 || op == 5) ? "R3" : "R4",
                        3'(op), 1'(i[0] ^ op[0]));
            end
        end

        // R7: write the three registers, read back.
        oc_txn(8'h17, 1'b1, 8'hA5);
        oc_txn(8'h18, 1'b1, 8'h3C);
        oc_txn(8'h19, 1'b1, 8'hE1);
        oc_txn(8'h17, 1'b0, 8'h00);
        oc_txn(8'h18, 1'b0, 8'h00);
        oc_txn(8'h19, 1'b0, 8'h00);

        // R8: writes to version and unmapped addresses change nothing.
        for (int a = 0; a < 256; a++) begin
            if (a < 8'h17 || a > 8'h19) oc_txn(8'(a), 1'b1, 8'(a ^ 8'h5A));
        end
        for (int a = 0; a < 256; a++) oc_txn(8'(a), 1'b0, 8'h00);

        // R9: request during an external cycle is dropped.
        bc = 32'hDEAD_BEEF;
        issue(3'd1, 1'b0);
        req_op = 3'd6; imm_n = 8'h17; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "busy after ignored req", busy, 0);
        @(negedge clk);
        check("R9", "still idle", {busy, io_addr}, 0);

        // R9: request during pseudo-cycle one is dropped.
        imm_n = 8'h18;
        issue(3'd6, 1'b0);
        req_op = 3'd4; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "p2 addr held", io_addr, 32'h18);
        @(negedge clk);
        check("R9", "idle after p2", {busy, io_addr}, 0);

        // R9: reserved class never starts.
        issue(3'd7, 1'b0);
        check("R9", "reserved op", {busy, done, io_addr}, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule